// File: doc/BRIEF.md
# Clock-Gated One-Hot Row Address Shifter

This block chooses which sensor row is active. It holds a single active bit, called the token, in a chain of registers that has one register per row. A start-of-frame pulse places the token on row 0. After that, each row-advance strobe moves the token one row further. When the token moves past the final row, the block raises a frame-done flag for exactly one cycle, and the select vector goes to all zeros until the next start-of-frame pulse.

The register chain is divided into leaf sections of equal size. The shift clock reaches the sections through a two-level tree of latch-based clock gates: group gates feed leaf gates. Each leaf gate is enabled by the registers of its own section and by the final register of the section before it. On a normal step, therefore, only the section that holds the token and the section that receives it get a clock edge. The group gate above a set of leaves is enabled by the OR of their enables. Reset and start-of-frame open every gate so that all sections can be cleared or loaded.

Top module: `row_select_shifter`

## Requirements
- R1: While `rst` is high at a clock edge, `row_sel` becomes all zeros and `frame_done` becomes 0 after that edge. Reset takes priority over every other input.
- R2: `row_sel` never has more than one bit set.
- R3: When `sof` is high at an edge (and `rst` is low), `row_sel` becomes exactly bit 0 after that edge, even if `adv` is also high.
- R4: When `adv` is high and `sof` is low at an edge, a token at bit i moves to bit i+1 after that edge. When `adv` is low, `row_sel` keeps its value.
- R5: When `adv` is high while the token is at bit ROWS-1, the next output has `row_sel` all zeros and `frame_done` high. `frame_done` is high for that one cycle only.
- R6: When `adv` is high and no bit of `row_sel` is set, nothing changes: `row_sel` stays zero and `frame_done` stays low.
- R7: When neither `rst` nor `sof` is high, no more than two leaf sections have their gate enabled. A section whose gate is closed keeps its register values.
- R8: With the default parameters, ROWS is 768. Starting from a `sof`, the 768th advance is the one that raises `frame_done`. Along the way the token passes through every row, including the row that crosses from one section into the next.
- R9: A `sof` received in the middle of a frame moves the token back to row 0 straight away. It does not raise `frame_done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Ungated shift clock |
| rst | input | 1 | Synchronous active-high reset |
| sof | input | 1 | Start-of-frame pulse; loads the token into row 0 |
| adv | input | 1 | Row-advance strobe; moves the token one row on |
| row_sel | output | ROWS | One-hot row-select vector, registered |
| frame_done | output | 1 | One-cycle flag raised when the token leaves the final row |

## Verification
The token is driven through four patterns, and each one separates a different kind of fault:
- **Back-to-back advances.** These show whether the shift reaches the next row and whether the token survives the move across a section boundary, where the enable depends on the carry from the neighbouring section.
- **Advances mixed with idle cycles.** These show whether the token holds its row when `adv` is low.
- **A full frame of 768 advances.** This shows whether the frame length and the one-cycle `frame_done` pulse are correct.
- **`sof` and `adv` together, and `adv` with no token present.** These check the priority of start-of-frame over advance, and confirm that an advance on an empty chain does nothing.

// File: rtl/rowsel_pkg.sv
package rowsel_pkg;
  function automatic int ceil_div(input int a, input int b);
    return (a + b - 1) / b;
  endfunction
endpackage

// File: rtl/rs_clock_gate.sv
module rs_clock_gate (
  input  logic clk,
  input  logic en,
  output logic gclk
);
  logic en_q;

  // enable is captured while clk is low, so gclk cannot glitch
  always_latch begin
    if (!clk) en_q = en;
  end

  assign gclk = clk & en_q;
endmodule

// File: rtl/rs_gate_tree.sv
module rs_gate_tree #(
  parameter int NLEAF  = 48,
  parameter int FANOUT = 4
) (
  input  logic             clk,
  input  logic [NLEAF-1:0] leaf_en,
  output logic [NLEAF-1:0] leaf_gclk
);
  localparam int NGRP = rowsel_pkg::ceil_div(NLEAF, FANOUT);
  localparam int PADW = NGRP * FANOUT;

  logic [PADW-1:0] en_pad;
  logic [NGRP-1:0] grp_en;
  logic [NGRP-1:0] grp_gclk;

  assign en_pad = PADW'(leaf_en);

  for (genvar g = 0; g < NGRP; g++) begin : g_grp
    assign grp_en[g] = |en_pad[g*FANOUT +: FANOUT];
    rs_clock_gate u_gate (.clk(clk), .en(grp_en[g]), .gclk(grp_gclk[g]));
  end

  for (genvar s = 0; s < NLEAF; s++) begin : g_leaf
    rs_clock_gate u_gate (.clk(grp_gclk[s / FANOUT]), .en(leaf_en[s]), .gclk(leaf_gclk[s]));
  end
endmodule

// File: rtl/rs_row_section.sv
module rs_row_section #(
  parameter int  SEC_ROWS = 16,
  parameter bit  IS_FIRST = 1'b0
) (
  input  logic                clk,
  input  logic                gclk,
  input  logic                rst,
  input  logic                sof,
  input  logic                adv,
  input  logic                en,
  input  logic                carry_in,
  output logic [SEC_ROWS-1:0] bits
);
  localparam logic [SEC_ROWS-1:0] LOAD_VAL = IS_FIRST ? SEC_ROWS'(1) : '0;

  always_ff @(posedge gclk) begin
    if (rst)      bits <= '0;
    else if (sof) bits <= LOAD_VAL;
    else if (adv) bits <= {bits[SEC_ROWS-2:0], carry_in};
  end

  // R7: a section left without a clock keeps its contents
  assert_idle_hold_R7: assert property (@(posedge clk) disable iff (rst)
    !en |=> $stable(bits));
endmodule

// File: rtl/row_select_shifter.sv
module row_select_shifter #(
  parameter int ROWS     = 768,
  parameter int SEC_ROWS = 16,
  parameter int FANOUT   = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            sof,
  input  logic            adv,
  output logic [ROWS-1:0] row_sel,
  output logic            frame_done
);
  localparam int NSEC = ROWS / SEC_ROWS;

  logic [NSEC-1:0] leaf_req;
  logic [NSEC-1:0] leaf_en;
  logic [NSEC-1:0] leaf_gclk;
  logic [NSEC-1:0] carry;

  for (genvar s = 0; s < NSEC; s++) begin : g_sec
    if (s == 0) begin : g_head
      assign carry[s] = 1'b0;
    end else begin : g_body
      assign carry[s] = row_sel[s*SEC_ROWS-1];
    end
    assign leaf_req[s] = (|row_sel[s*SEC_ROWS +: SEC_ROWS]) | carry[s];
    assign leaf_en[s]  = rst | sof | (adv & leaf_req[s]);

    rs_row_section #(.SEC_ROWS(SEC_ROWS), .IS_FIRST(s == 0)) u_sec (
      .clk(clk), .gclk(leaf_gclk[s]), .rst(rst), .sof(sof), .adv(adv),
      .en(leaf_en[s]), .carry_in(carry[s]),
      .bits(row_sel[s*SEC_ROWS +: SEC_ROWS])
    );
  end

  rs_gate_tree #(.NLEAF(NSEC), .FANOUT(FANOUT)) u_tree (
    .clk(clk), .leaf_en(leaf_en), .leaf_gclk(leaf_gclk)
  );

  always_ff @(posedge clk) begin
    if (rst) frame_done <= 1'b0;
    else     frame_done <= adv & ~sof & row_sel[ROWS-1];
  end

  assert_onehot_R2: assert property (@(posedge clk) disable iff (rst)
    $onehot0(row_sel));
  assert_sof_load_R3: assert property (@(posedge clk) disable iff (rst)
    (sof && !rst) |=> (row_sel == ROWS'(1)));
  assert_shift_R4: assert property (@(posedge clk) disable iff (rst)
    (adv && !sof && !rst) |=> (row_sel == ($past(row_sel) << 1)));
  assert_done_pulse_R5: assert property (@(posedge clk) disable iff (rst)
    frame_done |=> !frame_done);
  assert_gate_count_R7: assert property (@(posedge clk) disable iff (rst)
    !sof |-> ($countones(leaf_en) <= 2));
endmodule

// File: tb/row_select_shifter_test.sv
module row_select_shifter_test;
  localparam int ROWS = 768;
  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic sof;
    logic adv;
    int   idx;
    logic done;
  } vec_t;

  localparam int NVEC = 8;
  localparam vec_t VECS [NVEC] = '{
    '{1'b0, 1'b1, -1, 1'b0},   // R6 advance with no token
    '{1'b1, 1'b0,  0, 1'b0},   // R3 load
    '{1'b0, 1'b0,  0, 1'b0},   // R4 hold
    '{1'b0, 1'b1,  1, 1'b0},   // R4 shift
    '{1'b0, 1'b1,  2, 1'b0},   // R4 shift
    '{1'b0, 1'b0,  2, 1'b0},   // R4 hold
    '{1'b1, 1'b1,  0, 1'b0},   // R3 sof beats adv
    '{1'b0, 1'b1,  1, 1'b0}    // R4 shift
  };

  logic clk = 1'b0;
  logic rst, sof, adv;
  logic [ROWS-1:0] row_sel;
  logic frame_done;
  int checks = 0;
  int errors = 0;
  int idx = -1;

  always #(CLK_PERIOD/2) clk = ~clk;

  row_select_shifter uut (
    .clk(clk), .rst(rst), .sof(sof), .adv(adv),
    .row_sel(row_sel), .frame_done(frame_done)
  );

  function automatic logic [ROWS-1:0] onehot(input int i);
    logic [ROWS-1:0] v = '0;
    if (i >= 0) v[i] = 1'b1;
    return v;
  endfunction

  task automatic check(input string req, input int e_idx, input logic e_done);
    checks++;
    if (row_sel !== onehot(e_idx) || frame_done !== e_done) begin
      errors++;
      $display("FAIL %s: row_sel=%h done=%b, expected row %0d done=%b",
               req, row_sel, frame_done, e_idx, e_done);
    end
  endtask

  task automatic drive(input logic r, input logic s, input logic a);
    @(negedge clk);
    rst = r; sof = s; adv = a;
    @(posedge clk);
    #1;
  endtask

  // model step from the requirements
  task automatic step(input logic s, input logic a, input string req);
    logic d = 1'b0;
    drive(1'b0, s, a);
    if (s) idx = 0;
    else if (a && idx == ROWS-1) begin idx = -1; d = 1'b1; end
    else if (a && idx >= 0) idx++;
    check(req, idx, d);
  endtask

  initial begin
    rst = 1'b1; sof = 1'b0; adv = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    check("R1", -1, 1'b0);

    for (int i = 0; i < NVEC; i++) begin
      drive(1'b0, VECS[i].sof, VECS[i].adv);
      check($sformatf("R3/R4/R6 vec%0d", i), VECS[i].idx, VECS[i].done);
      idx = VECS[i].idx;
    end

    // R7 cross the first section boundary (15 -> 16 -> 17)
    while (idx < 17) step(1'b0, 1'b1, "R7");

    // R9 restart mid-frame
    step(1'b1, 1'b0, "R9");

    // R8 full frame: 767 advances to the last row, then one more
    for (int i = 0; i < ROWS-1; i++) step(1'b0, 1'b1, "R8");
    check("R8", ROWS-1, 1'b0);
    step(1'b0, 1'b1, "R5");
    step(1'b0, 1'b0, "R5");
    step(1'b0, 1'b1, "R6");

    // R1 reset in the middle of a frame
    step(1'b1, 1'b0, "R3");
    step(1'b0, 1'b1, "R4");
    drive(1'b1, 1'b1, 1'b1);
    idx = -1;
    check("R1", -1, 1'b0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule